// File: doc/BRIEF.md
# In-Place Frame Grayscale Converter

This block turns a colour frame that sits in a frame buffer into a grayscale frame, overwriting it in place. A single start pulse launches a pass over every pixel address of the frame. For each address the block reads the stored pixel, forms the sum of its red, green and blue channels with two adders, and divides the sum by three exactly. It then writes a pixel carrying that mean in all three channel fields back to the same address.

The block drives the read port and the write port of a dual-port buffer directly. Its pipeline accepts a new pixel on every clock. The write address is delayed to match the buffer's read latency, so a frame of N pixels takes N plus the pipeline depth cycles. Busy and done outputs let the surrounding control logic know when the buffer holds the finished image. The frame is 320x240 by default, and is meant to be clocked at 25 MHz when a push-button request starts it.

Top module: `frame_gray_sweep`

## Requirements
- R1: After reset is asserted, busy_o, done_o, rd_en_o and wr_en_o are all 0.
- R2: A pixel word is {R,G,B}, with R in bits 23:16, G in bits 15:8 and B in bits 7:0. The gray value is floor((R+G+B)/3), computed exactly for every sum from 0 to 765.
- R3: Every written pixel carries the gray value in all three channel fields. A pass over a frame that is already gray leaves it unchanged.
- R4: In the cycle after an accepted start, reads begin at address 0 and step by one per cycle to address N-1. Writes go to the same addresses, in the same order, once each.
- R5: The pixel read in cycle t is written in cycle t+RD_LAT+1. busy_o stays high for exactly N+RD_LAT+1 cycles per pass.
- R6: done_o is high for exactly one cycle, in the cycle after the write to address N-1. busy_o is low in that cycle.
- R7: A start_i that arrives while busy_o is high is ignored. The pass keeps its address sequence and its write count.
- R8: A start_i while idle begins a new pass, and passes can be repeated back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a pass |
| rd_en_o | output | 1 | Buffer read enable |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 24 | Pixel returned RD_LAT cycles after the read |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | ADDR_W | Buffer write address |
| wr_data_o | output | 24 | Gray pixel to store |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse when the pass has finished |

## Verification
The assertions check on every cycle the following properties:
- each registered quotient is the exact floor of its sum divided by three;
- every written pixel has three equal channel fields;
- read addresses and write addresses each advance by one while active;
- a start during a pass does not disturb the address counter;
- done only follows the end of busy.

The remaining properties appear only in the bench scenarios, which check the buffer contents at the end of each pass:
- the read-to-write distance for each address;
- the exact busy length;
- a single done pulse;
- repeated passes, including the second pass over an already gray frame.

// File: rtl/frame_gray_pkg.sv
package frame_gray_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;
  localparam int SUM_W = CH_W + 2;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } pix_t;
endpackage

// File: rtl/gray_seq.sv
module gray_seq #(
  parameter int ADDR_W = 17,
  parameter int N_PIX  = 76800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              last_wr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_PIX - 1);

  logic              busy_q, rd_act_q, done_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rd_act_q <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q   <= 1'b1;
        rd_act_q <= 1'b1;
        addr_q   <= '0;
      end else begin
        if (rd_act_q) begin
          if (addr_q == LAST) rd_act_q <= 1'b0;
          else                addr_q   <= addr_q + 1'b1;
        end
        if (last_wr_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rd_en_o   = rd_act_q;
  assign rd_addr_o = addr_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  a_r4_rd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_q && $past(rd_act_q)) |-> (addr_q == $past(addr_q) + 1'b1));

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_act_q && start_i && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r6_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/pipe_delay.sv
module pipe_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/rgb_mean.sv
module rgb_mean
  import frame_gray_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  pix_t pix_i,
  output pix_t pix_o
);
  // floor(x/3) as (x * ceil(2^S/3)) >> S, exact for x < 2^SUM_W
  localparam int          SH     = SUM_W + 1;
  localparam int          PROD_W = 2 * SUM_W + 2;
  localparam logic [SH:0] MAGIC  = (SH+1)'(((1 << SH) + 2) / 3);

  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod;
  logic [CH_W-1:0]   gray, gray_q;

  assign sum  = SUM_W'(pix_i.r) + SUM_W'(pix_i.g) + SUM_W'(pix_i.b);
  assign prod = PROD_W'(sum) * PROD_W'(MAGIC);
  assign gray = prod[SH +: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gray_q <= '0;
    else if (valid_i) gray_q <= gray;
  end

  assign pix_o = '{r: gray_q, g: gray_q, b: gray_q};

  a_r2_exact_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((int'(gray_q) * 3 <= int'($past(sum))) &&
                 (int'($past(sum)) - int'(gray_q) * 3 < 3)));
endmodule

// File: rtl/frame_gray_sweep.sv
module frame_gray_sweep
  import frame_gray_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int RD_LAT  = 1,
  parameter int N_PIX   = FRAME_W * FRAME_H,
  parameter int ADDR_W  = $clog2(N_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [PIX_W-1:0]  rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PIX_W-1:0]  wr_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_PIX - 1);

  logic              vld_al, wr_en_q, last_wr;
  logic [ADDR_W-1:0] addr_al, wr_addr_q;
  pix_t              mean_pix;

  gray_seq #(.ADDR_W(ADDR_W), .N_PIX(N_PIX)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .last_wr_i (last_wr),
    .rd_en_o, .rd_addr_o, .busy_o, .done_o
  );

  // align valid/address with the data returned by the buffer
  pipe_delay #(.W(ADDR_W + 1), .DEPTH(RD_LAT)) u_dly (
    .clk_i, .rst_ni,
    .d_i ({rd_en_o, rd_addr_o}),
    .q_o ({vld_al, addr_al})
  );

  rgb_mean u_mean (
    .clk_i, .rst_ni,
    .valid_i (vld_al),
    .pix_i   (pix_t'(rd_data_i)),
    .pix_o   (mean_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      wr_en_q   <= vld_al;
      wr_addr_q <= addr_al;
    end
  end

  assign last_wr   = wr_en_q && (wr_addr_q == LAST);
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = mean_pix;

  a_r3_equal_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o[23:16] == wr_data_o[15:8] && wr_data_o[15:8] == wr_data_o[7:0]));

  a_r4_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wr_en_o && !rd_en_o));
endmodule

// File: tb/frame_gray_sweep_tb.sv
module frame_gray_sweep_tb;
  localparam int FW = 8, FH = 4, N = FW * FH, LAT = 1, AW = $clog2(N);
  localparam int NV = 12;
  // {pixel, expected gray}
  localparam logic [31:0] VEC [NV] = '{
    32'h000000_00, 32'hFFFFFF_FF, 32'hFFFFFE_FE, 32'h010000_00,
    32'h020000_00, 32'h030000_01, 32'hFF0000_55, 32'hFFFF00_AA,
    32'h102030_20, 32'h7F8081_80, 32'h0100FF_55, 32'h000002_00};

  logic clk = 0, rst_n = 0, start = 0;
  logic rd_en, wr_en, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [23:0] rd_data, wr_data;
  logic [23:0] mem [N];

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt, done_cnt, busy_cyc, ord_err, lat_err, done_busy_err, exp_wr, exp_rd;
  int rd_cyc [N];

  always #2 clk = ~clk;

  frame_gray_sweep #(.FRAME_W(FW), .FRAME_H(FH), .RD_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done));

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gray_of(input logic [23:0] p);
    return 8'((int'(p[23:16]) + int'(p[15:8]) + int'(p[7:0])) / 3);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cyc++;
    if (rd_en) begin
      if (int'(rd_addr) != exp_rd) ord_err++;
      rd_cyc[rd_addr] = cyc;
      exp_rd++;
    end
    if (wr_en) begin
      if (int'(wr_addr) != exp_wr) ord_err++;
      if (cyc - rd_cyc[wr_addr] != LAT + 1) lat_err++;
      exp_wr++;
      wr_cnt++;
    end
    if (done) begin
      done_cnt++;
      if (busy) done_busy_err++;
    end
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_sweep(input int start_len, input int poke_at);
    wr_cnt = 0; done_cnt = 0; busy_cyc = 0; ord_err = 0; lat_err = 0;
    done_busy_err = 0; exp_wr = 0; exp_rd = 0;
    @(negedge clk) start = 1;
    repeat (start_len) @(negedge clk);
    start = 0;
    for (int i = 0; i < 3 * N; i++) begin
      if (i == poke_at) start = 1;
      else if (i == poke_at + 1) start = 0;
      @(negedge clk);
      if (done_cnt != 0) break;
    end
    start = 0;
    repeat (4) @(negedge clk);
    chk(ord_err == 0, "R4 address order", ord_err, 0);
    chk(wr_cnt == N, "R4/R7 write count", wr_cnt, N);
    chk(lat_err == 0, "R5 read-to-write distance", lat_err, 0);
    chk(busy_cyc == N + LAT + 1, "R5 busy length", busy_cyc, N + LAT + 1);
    chk(done_cnt == 1, "R6 done pulses", done_cnt, 1);
    chk(done_busy_err == 0, "R6 busy low with done", done_busy_err, 0);
  endtask

  logic [23:0] src [N];
  int bad;

  initial begin
    for (int i = 0; i < N; i++) begin
      src[i] = (i < NV) ? VEC[i][31:8] : {8'(i * 7), 8'(i * 13 + 5), 8'(i * 29 + 200)};
      mem[i] = src[i];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1 reset outputs",
        {busy, done, rd_en, wr_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // pass 1: table vectors, R8 start from idle
    run_sweep(1, -1);
    for (int i = 0; i < NV; i++)
      chk(mem[i] == {3{VEC[i][7:0]}}, "R2/R3 table gray", mem[i], {3{VEC[i][7:0]}});
    bad = 0;
    for (int i = NV; i < N; i++) if (mem[i] != {3{gray_of(src[i])}}) bad++;
    chk(bad == 0, "R2 computed pattern", bad, 0);

    // pass 2: already gray, start poked mid-pass (R7), contents unchanged (R3)
    for (int i = 0; i < N; i++) src[i] = mem[i];
    run_sweep(1, 10);
    bad = 0;
    for (int i = 0; i < N; i++) if (mem[i] != src[i]) bad++;
    chk(bad == 0, "R3 idempotent pass", bad, 0);

    // pass 3: new colours, start held for several cycles (R7, R8)
    for (int i = 0; i < N; i++) begin
      src[i] = {8'(255 - i), 8'(i * 3), 8'(i * 11 + 1)};
      mem[i] = src[i];
    end
    run_sweep(5, -1);
    bad = 0;
    for (int i = 0; i < N; i++) if (mem[i] != {3{gray_of(src[i])}}) bad++;
    chk(bad == 0, "R8 repeated pass result", bad, 0);
    chk(!busy && !rd_en && !wr_en, "R1 idle after pass", {busy, rd_en, wr_en}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule